// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets clocked logic read and write an asynchronous static RAM of 512K bytes. The RAM has one shared bidirectional 8-bit data bus and active-low chip-select, write-enable and output-enable strobes. The client presents an address, a byte of write data and a direction flag with a one-cycle request strobe while the sequencer is idle. It then watches a busy flag and a one-clock completion pulse, and on reads it collects the returned byte.

The sequencer converts every nanosecond limit of the RAM speed grade into a whole number of clock cycles. Each count rounds up and is at least one cycle. From these counts it spaces the strobe edges. Output enable stays high for the whole of a write, so the shorter write-pulse limit applies. The sequencer turns on its own data driver only after the RAM has let go of the bus. It adds idle turnaround cycles when the bus changes direction.

The data bus is split at the block edge into an output value, an output enable and an input value, so that the pad ring or the bench can form the tri-state pin.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, chip select, write enable and output enable are high, the data driver is off, and busy and done are low.
- R2: Write enable is low only while chip select is low. Output enable is never low while write enable is low or while the data driver is on.
- R3: A write holds chip select low for one setup cycle before write enable falls. Write enable then stays low for max(WP, WHZ+DW, WC-2) cycles, which is 3 at 125 MHz with default timing. Chip select is released one cycle after write enable rises, so chip select is low for 5 cycles in total.
- R4: The data driver turns on WHZ cycles after write enable falls (1 cycle by default). It stays on through the cycle after write enable rises and is off the cycle after that. It is never on while the RAM drives the bus.
- R5: A read lowers chip select and output enable together. Read data is registered at the end of cycle max(AA, OE), which is cycle 3 by default. Chip select and output enable rise after max(AA,OE) + max(1, RC-max(AA,OE)) cycles, which is 4 by default.
- R6: Done is high for exactly one clock, in the cycle after each access ends. Busy is high from the cycle after acceptance until that cycle. The RAM address stays stable while busy.
- R7: A read that directly follows a write waits one turnaround cycle, so chip select falls 2 cycles after acceptance instead of 1. A write after a read adds no cycle with the default timing.
- R8: A read returns the byte last written to the same address, across directed and random mixes of reads and writes.
- R9: A request raised while busy is ignored and leaves the RAM contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_busy | output | 1 | An access is in progress |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Byte captured by the last read |
| sram_addr | output | 19 | RAM address |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_dq_o | output | 8 | Value driven onto the data bus |
| sram_dq_oe | output | 1 | Data bus driver enable |
| sram_dq_i | input | 8 | Value read from the data bus |

## Verification
The bench goes after bus ownership. A driver that turns on in the same cycle write enable falls, or stays on into a read, makes both sides drive the bus, and the RAM model flags it. A driver that turns off as write enable rises stores a corrupt byte. Read-after-write pairs reveal a missing turnaround through the chip-select latency, and strobe widths are counted to catch off-by-one pulse lengths. A request pulsed mid-access tests that a sequencer accepting work outside idle would overwrite a byte, and random traffic compares all read data against a reference array.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_RC_NS       = 20,
  parameter int T_AA_NS       = 20,
  parameter int T_OE_NS       = 10,
  parameter int T_WC_NS       = 20,
  parameter int T_WP_NS       = 14,
  parameter int T_DW_NS       = 9,
  parameter int T_WHZ_NS      = 5,
  parameter int T_OHZ_NS      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_busy,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);

  function automatic int to_cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_RC    = to_cyc(T_RC_NS);
  localparam int N_AA    = to_cyc(T_AA_NS);
  localparam int N_OE    = to_cyc(T_OE_NS);
  localparam int N_WC    = to_cyc(T_WC_NS);
  localparam int N_WP    = to_cyc(T_WP_NS);
  localparam int N_DW    = to_cyc(T_DW_NS);
  localparam int N_WHZ   = to_cyc(T_WHZ_NS);
  localparam int N_OHZ   = to_cyc(T_OHZ_NS);
  localparam int RD_N    = max2(N_AA, N_OE);
  localparam int RD_HOLD = max2(1, N_RC - RD_N);
  localparam int WE_N    = max2(max2(N_WP, N_WHZ + N_DW), N_WC - 2);
  localparam int WAR_GAP = max2(0, N_OHZ - N_WHZ - 1);
  localparam int CNT_MAX = max2(max2(WE_N, RD_N), max2(RD_HOLD, WAR_GAP + 1));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {
    IDLE, RD_SETUP, RD_WAIT, RD_CAPTURE, WR_SETUP, WR_PULSE, WR_END, TURNAROUND
  } state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  ta_end;
  logic              wr_q;
  logic              last_wr;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= IDLE;
      cnt       <= '0;
      ta_end    <= '0;
      wr_q      <= 1'b0;
      last_wr   <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rsp_rdata <= '0;
      rsp_done  <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          wr_q    <= req_write;
          cnt     <= '0;
          if (req_write) begin
            if (!last_wr && WAR_GAP > 0) begin
              ta_end <= CNT_W'(WAR_GAP > 0 ? WAR_GAP - 1 : 0);
              state  <= TURNAROUND;
            end else begin
              state <= WR_SETUP;
            end
          end else if (last_wr) begin
            ta_end <= '0;
            state  <= TURNAROUND;
          end else begin
            state <= RD_SETUP;
          end
        end
        TURNAROUND: if (cnt == ta_end) begin
          cnt   <= '0;
          state <= wr_q ? WR_SETUP : RD_SETUP;
        end else begin
          cnt <= cnt + 1'b1;
        end
        RD_SETUP, RD_WAIT: if (cnt == CNT_W'(RD_N - 1)) begin
          rsp_rdata <= sram_dq_i;
          cnt       <= '0;
          state     <= RD_CAPTURE;
        end else begin
          cnt   <= cnt + 1'b1;
          state <= RD_WAIT;
        end
        RD_CAPTURE: if (cnt == CNT_W'(RD_HOLD - 1)) begin
          state    <= IDLE;
          rsp_done <= 1'b1;
          last_wr  <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        WR_SETUP: begin
          cnt   <= '0;
          state <= WR_PULSE;
        end
        WR_PULSE: if (cnt == CNT_W'(WE_N - 1)) begin
          state <= WR_END;
        end else begin
          cnt <= cnt + 1'b1;
        end
        WR_END: begin
          state    <= IDLE;
          rsp_done <= 1'b1;
          last_wr  <= 1'b1;
        end
        default: state <= IDLE;
      endcase
    end
  end

  logic in_read;
  logic in_write;
  assign in_read    = (state == RD_SETUP) || (state == RD_WAIT) || (state == RD_CAPTURE);
  assign in_write   = (state == WR_SETUP) || (state == WR_PULSE) || (state == WR_END);
  assign sram_cs_n  = !(in_read || in_write);
  assign sram_oe_n  = !in_read;
  assign sram_we_n  = (state != WR_PULSE);
  assign sram_dq_oe = ((state == WR_PULSE) && (cnt >= CNT_W'(N_WHZ))) || (state == WR_END);
  assign sram_addr  = addr_q;
  assign sram_dq_o  = wdata_q;
  assign req_busy   = (state != IDLE);

  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_cs_n); // R2
  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n); // R2
  AST_DRV_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (!sram_cs_n && sram_oe_n)); // R4
  AST_DRV_AFTER_WE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (!sram_we_n && $past(!sram_we_n))); // R4
  AST_DRV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> sram_dq_oe); // R4
  AST_OE_AFTER_DRV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_oe_n) |-> !$past(sram_dq_oe)); // R7
  AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R6
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_busy && $past(req_busy)) |-> $stable(sram_addr)); // R6

endmodule

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;
  localparam int AW = 19;
  localparam int DW = 8;
  localparam int PER = 8;
  localparam int WE_LOW = 3;
  localparam int WHZ_C = 1;
  localparam int RD_CS = 4;
  localparam int WR_CS = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_busy, rsp_done, sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [DW-1:0] rsp_rdata, sram_dq_o, sram_dq_i;
  logic [AW-1:0] sram_addr;

  always #(PER/2) clk = ~clk;

  sram_async_ctrl i_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_busy(req_busy),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i));

  logic [DW-1:0] ram_mem [int];
  logic [DW-1:0] ref_mem [int];
  logic ram_drv;

  function automatic logic [DW-1:0] ram_rd(input logic [AW-1:0] a);
    return ram_mem.exists(int'(a)) ? ram_mem[int'(a)] : 8'h5A;
  endfunction

  assign ram_drv   = !sram_cs_n && sram_we_n && !sram_oe_n;
  assign sram_dq_i = ram_drv ? ram_rd(sram_addr) : 8'hFF;

  always @(posedge sram_we_n)
    if (sram_cs_n === 1'b0)
      ram_mem[int'(sram_addr)] = sram_dq_oe ? sram_dq_o : 8'hEE;

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int we_lo = 0, cs_lo = 0;
  logic prev_we_low = 0, prev_cs_low = 0, prev_oe = 0, after_rise = 0, saw_wr = 0, prev_done = 0;

  always @(negedge clk) if (rst_n) begin
    if (sram_dq_oe && ram_drv) chk("R4 bus contention", 1, 0);
    if (!sram_oe_n && (!sram_we_n || sram_cs_n)) chk("R2 oe low outside read", 1, 0);
    if (!sram_we_n) begin
      we_lo++;
      saw_wr = 1;
      if (sram_dq_oe && !prev_oe) chk("R4 driver on delay", we_lo, WHZ_C + 1);
    end else if (prev_we_low) begin
      chk("R3 we low width", we_lo, WE_LOW);
      chk("R4 driver held after we rise", int'(sram_dq_oe), 1);
      we_lo = 0;
      after_rise = 1;
    end else if (after_rise) begin
      chk("R4 driver off two cycles after we rise", int'(sram_dq_oe), 0);
      after_rise = 0;
    end
    if (!sram_cs_n) cs_lo++;
    else if (prev_cs_low) begin
      chk(saw_wr ? "R3 write cs width" : "R5 read cs width", cs_lo, saw_wr ? WR_CS : RD_CS);
      cs_lo = 0;
      saw_wr = 0;
    end
    if (rsp_done && prev_done) chk("R6 done longer than one clock", 1, 0);
    prev_we_low = !sram_we_n;
    prev_cs_low = !sram_cs_n;
    prev_oe = sram_dq_oe;
    prev_done = rsp_done;
  end

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk("R6 busy after accept", int'(req_busy), 1);
    lat = 1;
    while (sram_cs_n) begin @(negedge clk); lat++; end
    while (!rsp_done) @(negedge clk);
    rd = rsp_rdata;
    if (wr) ref_mem[int'(a)] = d;
    else chk("R8 read data", int'(rd), ref_mem.exists(int'(a)) ? int'(ref_mem[int'(a)]) : -1);
  endtask

  localparam logic [27:0] VEC [12] = '{
    {1'b1, 19'h00000, 8'h3C}, {1'b1, 19'h7FFFF, 8'hC3}, {1'b1, 19'h2AAAA, 8'h55},
    {1'b1, 19'h55555, 8'hAA}, {1'b0, 19'h00000, 8'h00}, {1'b0, 19'h7FFFF, 8'h00},
    {1'b0, 19'h55555, 8'h00}, {1'b0, 19'h2AAAA, 8'h00}, {1'b1, 19'h00000, 8'hFF},
    {1'b1, 19'h40001, 8'h00}, {1'b0, 19'h40001, 8'h00}, {1'b0, 19'h00000, 8'h00}};

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [DW-1:0] rd;
    int lat;
    repeat (3) @(negedge clk);
    chk("R1 cs in reset", int'(sram_cs_n), 1);
    chk("R1 we in reset", int'(sram_we_n), 1);
    chk("R1 oe in reset", int'(sram_oe_n), 1);
    chk("R1 driver in reset", int'(sram_dq_oe), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy after reset", int'(req_busy), 0);
    chk("R1 done after reset", int'(rsp_done), 0);

    for (int i = 0; i < 12; i++) begin
      access(VEC[i][27], VEC[i][26:8], VEC[i][7:0], rd, lat);
      if (i == 4) chk("R7 read after write turnaround", lat, 2);
      if (i == 8) chk("R7 write after read no gap", lat, 1);
      if (i == 5) chk("R7 read after read no gap", lat, 1);
    end

    access(1, 19'h01234, 8'h11, rd, lat);
    access(1, 19'h04321, 8'h22, rd, lat);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 19'h01234;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 19'h04321; req_wdata = 8'h99;
    @(negedge clk);
    req_valid = 0; req_addr = 19'h00000;
    while (!rsp_done) @(negedge clk);
    chk("R6 read while address input changed", int'(rsp_rdata), 8'h11);
    access(0, 19'h04321, 8'h00, rd, lat);
    chk("R9 request during busy ignored", int'(rd), 8'h22);

    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      bit w;
      a = AW'((($urandom % 24) * 32'h2A5B3) ^ 32'h15);
      w = ($urandom % 2) == 1 || !ref_mem.exists(int'(a));
      access(w, a, DW'($urandom), rd, lat);
    end

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule